// File: doc/BRIEF.md
# Virtual-Circuit Link Transfer Handshake

This block carries one direction of a switch-to-switch physical channel. It holds both ends of that channel: the sending end in the upstream switch and the receiving end in the downstream switch. The two ends talk over three separate lines, one each for address, data and acknowledge. A scheduler outside the block grants one local source buffer at a time. The sender then reads a small mapping table that gives the destination buffer address in the neighbouring switch for that source buffer. It places that address on the address line, sends the payload on the data line, and reads the acknowledge line to decide whether the transfer succeeded.

Every attempt has a fixed length and is optimistic. The receiver compares the free space reported for the addressed queue with what the transfer needs. It then either writes the incoming data or drops all of it, and it drives the acknowledge line to match. When an attempt fails, the sender reports it, and the source buffer keeps its copy until the scheduler grants it again in a later round.

A parameter selects one of two link flavours:
- A narrow link that moves one word in a four-cycle attempt.
- A wide link that moves three four-word beats in an eight-cycle attempt.

The scheduler and the queue storage sit outside the block and appear only as ports.

Top module: `vcLinkXfer`

## Requirements
- R1: After reset the block is idle: busy, address-valid, data-valid, acknowledge, receive-write and both result pulses are 0.
- R2: The address line carries the destination address last written into the mapping-table entry of the granted source buffer, captured in the grant cycle; a later grant for another buffer is not taken while busy.
- R3: Narrow mode (LEVEL=1): with grant seen in cycle 1, the address is valid in cycle 2, data and acknowledge are valid in cycle 3, and the result pulse appears in cycle 4.
- R4: Narrow mode acknowledge polarity: the acknowledge line is 1 when the addressed queue reports 0 free entries (full, transfer fails) and 0 when it reports at least 1.
- R5: Wide mode (LEVEL=2): the address is valid in cycles 2 to 4 and held stable, data beats 0, 1, 2 follow in cycles 5, 6, 7 where beat k is payload bits [32k+31:32k], and the result pulse appears in cycle 8.
- R6: Wide mode acknowledge polarity: the acknowledge line is 1 throughout cycles 5 to 7 only when the addressed queue reports at least 3 free entries when the address arrives, else 0 throughout.
- R7: The receiver writes every data beat of an accepted transfer, addressed to the received destination, and writes no beat of a rejected one: never a partial set.
- R8: In the last cycle of each attempt exactly one of the success and fail pulses is 1 for one cycle, together with the source buffer index; success matches what the acknowledge line reported.
- R9: A grant raised while a transfer is in progress is ignored; after a failed attempt, a fresh grant of the same buffer retries it and succeeds when space is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Scheduler grant for one source buffer |
| grantBuf | input | BUF_W | Index of the granted source buffer |
| srcData | input | PAYLOAD_W | Payload of the granted buffer, beat 0 in the low bits |
| cfgWe | input | 1 | Mapping-table write enable |
| cfgIdx | input | BUF_W | Mapping-table entry to write |
| cfgAddr | input | DEST_W | Destination buffer address to store |
| rxFree | input | CNT_W | Free entries in the queue addressed by linkAddr |
| busy | output | 1 | Transfer in progress |
| doneOk | output | 1 | One-cycle pulse: attempt succeeded, release the data |
| doneFail | output | 1 | One-cycle pulse: attempt failed, keep the data |
| doneBuf | output | BUF_W | Source buffer of the finishing attempt |
| linkAddrVld | output | 1 | Address line active |
| linkAddr | output | DEST_W | Address line: destination buffer address |
| linkDataVld | output | 1 | Data line active |
| linkData | output | BEAT_W | Data line: current beat |
| linkAck | output | 1 | Acknowledge line from receiver to sender |
| rxWe | output | 1 | Receiver queue write strobe |
| rxWAddr | output | DEST_W | Destination queue of the write |
| rxWData | output | BEAT_W | Beat written to the queue |

## Verification
The checker watches, on every cycle, properties that tie the link lines together:
- The idle channel stays quiet.
- The address holds steady while it is being sent.
- Acknowledge and queue writes appear only in data cycles.
- The write strobe does not change between the beats of one attempt, so a write is all or none.
- The two result pulses never appear together, and a success follows the acknowledge level that means success.

The exact cycle each line turns on, the beat order, the address looked up for each buffer, both acknowledge polarities, the ignored grant and the retry after a failure depend on the stimulus. The bench's directed scenarios show these.

// File: rtl/vcLinkPkg.sv
package vcLinkPkg;
  // Strobes from the control sequencer to the datapath.
  typedef struct packed {
    logic       capture;    // grant accepted this cycle
    logic       addrVld;    // address line active
    logic       addrLast;   // final address cycle, receiver samples it
    logic       dataVld;    // data line active
    logic       ackSample;  // final data cycle, sender samples acknowledge
    logic       done;       // result cycle
    logic [1:0] beatIdx;    // beat on the data line
  } linkStrobeT;
endpackage

// File: rtl/vcLinkCtrl.sv
module vcLinkCtrl
  import vcLinkPkg::*;
#(
  parameter int LEVEL = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       grant,
  output logic       busy,
  output linkStrobeT st
);
  localparam int ADDR_CYC = (LEVEL == 1) ? 1 : 3;
  localparam int BEATS    = (LEVEL == 1) ? 1 : 3;
  localparam int LAST     = 2 + ADDR_CYC + BEATS;

  // cyc holds the cycle number of the attempt; 0 means idle (cycle 1 is the grant cycle).
  logic [3:0] cyc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cyc <= '0;
    end else if (cyc == 4'd0) begin
      if (grant) cyc <= 4'd2;
    end else if (cyc == 4'(LAST)) begin
      cyc <= '0;
    end else begin
      cyc <= cyc + 4'd1;
    end
  end

  always_comb begin
    busy         = (cyc != 4'd0);
    st.capture   = (cyc == 4'd0) && grant;
    st.addrVld   = (cyc >= 4'd2) && (cyc <= 4'(1 + ADDR_CYC));
    st.addrLast  = (cyc == 4'(1 + ADDR_CYC));
    st.dataVld   = (cyc >= 4'(2 + ADDR_CYC)) && (cyc <= 4'(1 + ADDR_CYC + BEATS));
    st.ackSample = (cyc == 4'(1 + ADDR_CYC + BEATS));
    st.done      = (cyc == 4'(LAST));
    st.beatIdx   = 2'(cyc - 4'(2 + ADDR_CYC));
  end
endmodule

// File: rtl/vcLinkData.sv
module vcLinkData
  import vcLinkPkg::*;
#(
  parameter int LEVEL   = 2,
  parameter int WORD_W  = 8,
  parameter int NUM_BUF = 4,
  parameter int DEST_W  = 4,
  parameter int CNT_W   = 4,
  localparam int BUF_W     = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int BEATS     = (LEVEL == 1) ? 1 : 3,
  localparam int BEAT_W    = WORD_W * ((LEVEL == 1) ? 1 : 4),
  localparam int PAYLOAD_W = BEAT_W * BEATS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  linkStrobeT           st,
  input  logic [BUF_W-1:0]     grantBuf,
  input  logic [PAYLOAD_W-1:0] srcData,
  input  logic                 cfgWe,
  input  logic [BUF_W-1:0]     cfgIdx,
  input  logic [DEST_W-1:0]    cfgAddr,
  input  logic [CNT_W-1:0]     rxFree,
  output logic                 doneOk,
  output logic                 doneFail,
  output logic [BUF_W-1:0]     doneBuf,
  output logic                 linkAddrVld,
  output logic [DEST_W-1:0]    linkAddr,
  output logic                 linkDataVld,
  output logic [BEAT_W-1:0]    linkData,
  output logic                 linkAck,
  output logic                 rxWe,
  output logic [DEST_W-1:0]    rxWAddr,
  output logic [BEAT_W-1:0]    rxWData
);
  // ---------------- sending end ----------------
  logic [DEST_W-1:0]    mapTbl [NUM_BUF];
  logic [BUF_W-1:0]     curBuf;
  logic [DEST_W-1:0]    curAddr;
  logic [PAYLOAD_W-1:0] curData;
  logic                 okQ;
  logic                 ackMeansOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BUF; i++) mapTbl[i] <= '0;
    end else if (cfgWe) begin
      mapTbl[cfgIdx] <= cfgAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBuf  <= '0;
      curAddr <= '0;
      curData <= '0;
      okQ     <= 1'b0;
    end else begin
      if (st.capture) begin
        curBuf  <= grantBuf;
        curAddr <= mapTbl[grantBuf];
        curData <= srcData;
      end
      if (st.ackSample) okQ <= ackMeansOk;
    end
  end

  always_comb begin
    linkAddrVld = st.addrVld;
    linkAddr    = st.addrVld ? curAddr : '0;
    linkDataVld = st.dataVld;
    linkData    = '0;
    for (int b = 0; b < BEATS; b++) begin
      if (st.dataVld && st.beatIdx == 2'(b)) linkData = curData[b*BEAT_W +: BEAT_W];
    end
    doneOk   = st.done && okQ;
    doneFail = st.done && !okQ;
    doneBuf  = curBuf;
  end

  // ---------------- receiving end ----------------
  logic [DEST_W-1:0] rxAddrQ;
  logic              rxAccept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxAddrQ  <= '0;
      rxAccept <= 1'b0;
    end else if (st.addrLast) begin
      rxAddrQ  <= linkAddr;
      rxAccept <= (rxFree >= CNT_W'(BEATS));
    end
  end

  // Acknowledge polarity differs between the two link flavours.
  generate
    if (LEVEL == 1) begin : g_ackFull
      assign linkAck    = st.dataVld && !rxAccept;
      assign ackMeansOk = !linkAck;
    end else begin : g_ackRoom
      assign linkAck    = st.dataVld && rxAccept;
      assign ackMeansOk = linkAck;
    end
  endgenerate

  always_comb begin
    rxWe    = st.dataVld && rxAccept;
    rxWAddr = rxAddrQ;
    rxWData = linkData;
  end
endmodule

// File: rtl/vcLinkXfer.sv
module vcLinkXfer
  import vcLinkPkg::*;
#(
  parameter int LEVEL   = 2,
  parameter int WORD_W  = 8,
  parameter int NUM_BUF = 4,
  parameter int DEST_W  = 4,
  parameter int CNT_W   = 4,
  localparam int BUF_W     = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int BEATS     = (LEVEL == 1) ? 1 : 3,
  localparam int BEAT_W    = WORD_W * ((LEVEL == 1) ? 1 : 4),
  localparam int PAYLOAD_W = BEAT_W * BEATS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 grant,
  input  logic [BUF_W-1:0]     grantBuf,
  input  logic [PAYLOAD_W-1:0] srcData,
  input  logic                 cfgWe,
  input  logic [BUF_W-1:0]     cfgIdx,
  input  logic [DEST_W-1:0]    cfgAddr,
  input  logic [CNT_W-1:0]     rxFree,
  output logic                 busy,
  output logic                 doneOk,
  output logic                 doneFail,
  output logic [BUF_W-1:0]     doneBuf,
  output logic                 linkAddrVld,
  output logic [DEST_W-1:0]    linkAddr,
  output logic                 linkDataVld,
  output logic [BEAT_W-1:0]    linkData,
  output logic                 linkAck,
  output logic                 rxWe,
  output logic [DEST_W-1:0]    rxWAddr,
  output logic [BEAT_W-1:0]    rxWData
);
  linkStrobeT st;

  vcLinkCtrl #(.LEVEL(LEVEL)) uCtrl (
    .clk(clk), .rstN(rstN), .grant(grant), .busy(busy), .st(st)
  );

  vcLinkData #(
    .LEVEL(LEVEL), .WORD_W(WORD_W), .NUM_BUF(NUM_BUF), .DEST_W(DEST_W), .CNT_W(CNT_W)
  ) uData (
    .clk(clk), .rstN(rstN), .st(st), .grantBuf(grantBuf), .srcData(srcData),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgAddr(cfgAddr), .rxFree(rxFree),
    .doneOk(doneOk), .doneFail(doneFail), .doneBuf(doneBuf),
    .linkAddrVld(linkAddrVld), .linkAddr(linkAddr), .linkDataVld(linkDataVld),
    .linkData(linkData), .linkAck(linkAck),
    .rxWe(rxWe), .rxWAddr(rxWAddr), .rxWData(rxWData)
  );
endmodule

// File: rtl/vcLinkChk.sv
module vcLinkChk #(
  parameter int LEVEL  = 2,
  parameter int DEST_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              doneOk,
  input logic              doneFail,
  input logic              linkAddrVld,
  input logic [DEST_W-1:0] linkAddr,
  input logic              linkDataVld,
  input logic              linkAck,
  input logic              rxWe
);
  localparam logic ACK_OK = (LEVEL != 1);

  // R1: an idle channel shows nothing on its lines
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!linkAddrVld && !linkDataVld && !rxWe && !doneOk && !doneFail));

  // R5: the address holds while it is being sent
  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (linkAddrVld && $past(linkAddrVld)) |-> $stable(linkAddr));

  // R6: acknowledge only during data cycles
  p_ack_in_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    linkAck |-> linkDataVld);

  // R7: queue writes only with a data beat
  p_write_with_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxWe |-> linkDataVld);

  // R7: all beats of one attempt written or none
  p_all_or_none_r7: assert property (@(posedge clk) disable iff (!rstN)
    (linkDataVld && $past(linkDataVld)) |-> (rxWe == $past(rxWe)));

  // R8: never both result pulses
  p_one_result_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOk && doneFail));

  // R8: success follows the acknowledge level that means success
  p_ok_follows_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneOk |-> ($past(linkDataVld) && ($past(linkAck) == ACK_OK)));
endmodule

bind vcLinkXfer vcLinkChk #(.LEVEL(LEVEL), .DEST_W(DEST_W)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .doneOk(doneOk), .doneFail(doneFail),
  .linkAddrVld(linkAddrVld), .linkAddr(linkAddr), .linkDataVld(linkDataVld),
  .linkAck(linkAck), .rxWe(rxWe)
);

// File: tb/tb_vcLinkXfer.sv
`timescale 1ns/100ps
module tb_vcLinkXfer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // shared table configuration
  logic       cfgWe = 1'b0;
  logic [1:0] cfgIdx = '0;
  logic [3:0] cfgAddr = '0;
  logic [3:0] tbl [4];

  // wide instance (default LEVEL=2)
  logic        g2 = 1'b0;
  logic [1:0]  gb2 = '0;
  logic [95:0] sd2 = '0;
  logic [3:0]  free2 = '0;
  logic        busy2, ok2, fail2, aV2, dV2, ack2, we2;
  logic [1:0]  db2;
  logic [3:0]  a2, wa2;
  logic [31:0] d2, wd2;

  vcLinkXfer dut (
    .clk(clk), .rstN(rstN), .grant(g2), .grantBuf(gb2), .srcData(sd2),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgAddr(cfgAddr), .rxFree(free2),
    .busy(busy2), .doneOk(ok2), .doneFail(fail2), .doneBuf(db2),
    .linkAddrVld(aV2), .linkAddr(a2), .linkDataVld(dV2), .linkData(d2),
    .linkAck(ack2), .rxWe(we2), .rxWAddr(wa2), .rxWData(wd2)
  );

  // narrow instance (LEVEL=1)
  logic       g1 = 1'b0;
  logic [1:0] gb1 = '0;
  logic [7:0] sd1 = '0;
  logic [3:0] free1 = '0;
  logic       busy1, ok1, fail1, aV1, dV1, ack1, we1;
  logic [1:0] db1;
  logic [3:0] a1, wa1;
  logic [7:0] d1, wd1;

  vcLinkXfer #(.LEVEL(1)) dutL1 (
    .clk(clk), .rstN(rstN), .grant(g1), .grantBuf(gb1), .srcData(sd1),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgAddr(cfgAddr), .rxFree(free1),
    .busy(busy1), .doneOk(ok1), .doneFail(fail1), .doneBuf(db1),
    .linkAddrVld(aV1), .linkAddr(a1), .linkDataVld(dV1), .linkData(d1),
    .linkAck(ack1), .rxWe(we1), .rxWAddr(wa1), .rxWData(wd1)
  );

  task automatic chk(input string req, input string what, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] idx, input logic [3:0] addr);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = idx; cfgAddr = addr; tbl[idx] = addr;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // R1: idle state after reset
  task automatic testReset();
    @(negedge clk);
    chk("R1", "busy", busy2, 0);
    chk("R1", "lines", {aV2, dV2, ack2, we2, ok2, fail2}, 0);
    chk("R1", "narrow lines", {busy1, aV1, dV1, ack1, we1, ok1, fail1}, 0);
  endtask

  // R2 R5 R6 R7 R8: one wide attempt; hold keeps the grant high (R9)
  task automatic xferL2(input string tag, input logic [1:0] b, input logic [95:0] pay,
                        input logic [3:0] free, input logic expOk, input bit hold);
    @(negedge clk);
    g2 = 1'b1; gb2 = b; sd2 = pay; free2 = free;
    for (int c = 2; c <= 8; c++) begin
      @(negedge clk);
      chk("R5", {tag, " addrVld"}, aV2, (c <= 4));
      chk("R5", {tag, " dataVld"}, dV2, (c >= 5 && c <= 7));
      if (c <= 4) chk("R2", {tag, " addr"}, a2, tbl[b]);
      if (c >= 5 && c <= 7) begin
        chk("R5", {tag, " beat"}, d2, pay[(c-5)*32 +: 32]);
        chk("R6", {tag, " ack"}, ack2, expOk);
        chk("R7", {tag, " write"}, we2, expOk);
        if (expOk) chk("R7", {tag, " waddr"}, wa2, tbl[b]);
      end
      if (c == 8) begin
        chk("R8", {tag, " ok"}, ok2, expOk);
        chk("R8", {tag, " fail"}, fail2, !expOk);
        chk("R8", {tag, " buf"}, db2, b);
      end else begin
        chk("R8", {tag, " no early result"}, {ok2, fail2}, 0);
      end
      if (hold) gb2 = b + 2'd1;
      else g2 = 1'b0;
    end
    g2 = 1'b0;
    if (hold) begin
      @(negedge clk);
      chk("R9", {tag, " grant ignored, idle after"}, {busy2, aV2}, 0);
    end
  endtask

  // R3 R4 R7 R8: one narrow attempt
  task automatic xferL1(input string tag, input logic [1:0] b, input logic [7:0] pay,
                        input logic [3:0] free, input logic expOk);
    @(negedge clk);
    g1 = 1'b1; gb1 = b; sd1 = pay; free1 = free;
    @(negedge clk);  // cycle 2
    g1 = 1'b0;
    chk("R3", {tag, " c2 addr"}, {aV1, dV1, a1}, {2'b10, tbl[b]});
    @(negedge clk);  // cycle 3
    chk("R3", {tag, " c3 data"}, {aV1, dV1, d1}, {2'b01, pay});
    chk("R4", {tag, " ack"}, ack1, !expOk);
    chk("R7", {tag, " write"}, we1, expOk);
    @(negedge clk);  // cycle 4
    chk("R3", {tag, " c4 result"}, {dV1, ok1, fail1, db1}, {1'b0, expOk, !expOk, b});
    @(negedge clk);
    chk("R3", {tag, " idle"}, busy1, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    cfgWrite(2'd0, 4'd5);
    cfgWrite(2'd1, 4'd9);
    cfgWrite(2'd2, 4'd12);
    cfgWrite(2'd3, 4'd3);
    xferL2("wide pass", 2'd1, 96'h33333333_22222222_11111111, 4'd3, 1'b1, 0);
    xferL2("wide short", 2'd2, 96'hCCCC0003_BBBB0002_AAAA0001, 4'd2, 1'b0, 0);
    xferL2("wide retry", 2'd2, 96'hCCCC0003_BBBB0002_AAAA0001, 4'd7, 1'b1, 0);
    xferL2("wide held grant", 2'd0, 96'h0BADF00D_DEADBEEF_01234567, 4'd5, 1'b1, 1);
    xferL1("narrow pass", 2'd3, 8'hA5, 4'd1, 1'b1);
    xferL1("narrow full", 2'd0, 8'h5A, 4'd0, 1'b0);
    xferL1("narrow retry", 2'd0, 8'h5A, 4'd4, 1'b1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule